// File: doc/BRIEF.md
# Toggle-Request Single-Port RAM

This block is a synchronous single-port memory. A requester starts an access by inverting a bit, not by raising a strobe. The requester owns one bit (`reqToggle`) and the memory owns another (`ackToggle`). When the two bits differ, a request is outstanding. The memory serves it on the next rising clock edge and then copies the requester's bit into its own, which retires the request.

A write-select input chooses the kind of access:

- **Read:** the memory loads a read-data register from the addressed word.
- **Write:** the memory stores the supplied word and leaves the read-data register alone.

While the two bits match, the memory is idle. The address, write data and write-select inputs are then ignored.

The storage depth, the data width and the address input width are parameters. The address is reduced modulo the depth. This lets a requester present a wide address, or one that wraps, without a separate range check. The logic is split into a control part and a datapath part:

- The control part detects the pending request and owns the acknowledge bit.
- The datapath holds the array and the read register.
- A small struct of strobes passes from the control to the datapath.

Top module: `toggle_req_ram`

## Requirements
- R1: While `reqToggle` equals `ackToggle`, no storage word, no `rdData` bit and no `ackToggle` bit changes, whatever `wrSel`, `addr` and `wrData` carry.
- R2: When the bits differ at a rising edge and `wrSel` is 0, `rdData` after that edge holds the word stored at the addressed location.
- R3: When the bits differ at a rising edge and `wrSel` is 1, `wrData` is stored at the addressed location, and a later read of that location returns it.
- R4: A write access leaves `rdData` unchanged.
- R5: Every access completes at the edge where the mismatch is first seen: after that edge, `ackToggle` equals the `reqToggle` value that was sampled at it.
- R6: The location used is `addr` modulo `DEPTH`, so addresses that differ by a multiple of `DEPTH` reach the same word.
- R7: Reset (active-low `rstN`) forces `ackToggle` and `rdData` to 0. It leaves the stored words intact.
- R8: Inverting `reqToggle` on every cycle yields one completed access per cycle, with reads and writes interleaved in any order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqToggle | input | 1 | Requester bit; inverting it asks for one access |
| wrSel | input | 1 | 1 selects a write, 0 a read |
| addr | input | ADDR_IN_W | Word address, reduced modulo DEPTH |
| wrData | input | DATA_W | Word to store on a write |
| ackToggle | output | 1 | Memory bit; equals reqToggle when no request is pending |
| rdData | output | DATA_W | Word returned by the last read |

## Verification
The bench builds the block with `DEPTH` = 12, `DATA_W` = 8 and `ADDR_IN_W` = 6. Because 12 is not a power of two, the modulo path is selected, not a plain truncation. With 6 address bits, addresses from 12 to 63 reach each word through several aliases, so wrap-around on both reads and writes is exercised. The narrow data width lets a reference array track every word during the random read/write runs. Those runs include back-to-back toggling and idle stretches in which the inputs change while the bits match.

// File: rtl/toggle_req_ram_pkg.sv
package toggle_req_ram_pkg;

  // Strobes handed from the request control to the storage datapath.
  typedef struct packed {
    logic doRead;
    logic doWrite;
  } ramStrobes_t;

  function automatic int idxWidth(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/toggle_req_ram_ctrl.sv
module toggle_req_ram_ctrl
  import toggle_req_ram_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqToggle,
  input  logic        wrSel,
  output logic        ackToggle,
  output ramStrobes_t strb
);

  logic ackBit;
  logic pending;

  // A request is outstanding while the two bits disagree.
  assign pending = reqToggle ^ ackBit;

  always_comb begin
    strb.doRead  = pending & ~wrSel;
    strb.doWrite = pending & wrSel;
  end

  // Retire the request by copying the requester bit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ackBit <= 1'b0;
    else if (pending) ackBit <= reqToggle;
  end

  assign ackToggle = ackBit;

  // R5: a pending request is retired at the very next edge
  assert_ack_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqToggle != ackBit) |=> (ackBit == $past(reqToggle)));

  // R1: with matching bits the acknowledge bit holds
  assert_idle_ack_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqToggle == ackBit) |=> $stable(ackBit));

  // R2: never a read and a write in the same cycle
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.doRead, strb.doWrite}));

endmodule

// File: rtl/toggle_req_ram_dp.sv
module toggle_req_ram_dp
  import toggle_req_ram_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_IN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobes_t       strb,
  input  logic [ADDR_IN_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int IDX_W   = idxWidth(DEPTH);
  localparam bit IS_POW2 = ((1 << IDX_W) == DEPTH);

  logic [IDX_W-1:0]  memIdx;
  logic [DATA_W-1:0] memArr [DEPTH];
  logic [DATA_W-1:0] rdReg;

  // Address reduction: truncation when the depth is a power of two,
  // a true modulo otherwise.
  generate
    if (IS_POW2) begin : g_wrapTrunc
      if (ADDR_IN_W > IDX_W) begin : g_drop
        logic [ADDR_IN_W-IDX_W-1:0] unusedHigh;
        assign unusedHigh = addr[ADDR_IN_W-1:IDX_W];
      end
      assign memIdx = addr[IDX_W-1:0];
    end else begin : g_wrapMod
      logic [31:0] wide;
      assign wide   = 32'(addr) % 32'(DEPTH);
      assign memIdx = wide[IDX_W-1:0];
    end
  endgenerate

  // Storage is deliberately not reset.
  always_ff @(posedge clk) begin
    if (strb.doWrite) memArr[memIdx] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdReg <= '0;
    else if (strb.doRead) rdReg <= memArr[memIdx];
  end

  assign rdData = rdReg;

  // R4: a write leaves the read register untouched
  assert_write_keeps_rd_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.doWrite |=> $stable(rdReg));

  // R1: without a read strobe the read register holds
  assert_idle_rd_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doRead |=> $stable(rdReg));

  // R6: the reduced index always lands inside the array
  assert_index_in_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doRead || strb.doWrite) |-> (int'(memIdx) < DEPTH));

endmodule

// File: rtl/toggle_req_ram.sv
module toggle_req_ram
  import toggle_req_ram_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_IN_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqToggle,
  input  logic                 wrSel,
  input  logic [ADDR_IN_W-1:0] addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic                 ackToggle,
  output logic [DATA_W-1:0]    rdData
);

  ramStrobes_t strb;

  toggle_req_ram_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqToggle (reqToggle),
    .wrSel     (wrSel),
    .ackToggle (ackToggle),
    .strb      (strb)
  );

  toggle_req_ram_dp #(
    .DEPTH     (DEPTH),
    .DATA_W    (DATA_W),
    .ADDR_IN_W (ADDR_IN_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData)
  );

  // R7: out of reset both state outputs read zero
  assert_reset_zero_R7: assert property (@(posedge clk)
    $rose(rstN) |-> (ackToggle == 1'b0 && rdData == '0));

endmodule

// File: tb/toggle_req_ram_tb.sv
`timescale 1ns/1ps
module toggle_req_ram_tb;

  localparam int DEPTH     = 12;
  localparam int DATA_W    = 8;
  localparam int ADDR_IN_W = 6;

  typedef struct packed {
    logic                 wr;
    logic [ADDR_IN_W-1:0] a;
    logic [DATA_W-1:0]    d;
    logic [DATA_W-1:0]    exp;   // expected rdData after the access
  } vec_t;

  // Directed table; addresses above 11 alias modulo 12.
  localparam vec_t VECS [10] = '{
    '{1'b1, 6'd3,  8'hA5, 8'h00},
    '{1'b1, 6'd15, 8'h3C, 8'h00},
    '{1'b0, 6'd3,  8'h00, 8'h3C},
    '{1'b1, 6'd0,  8'h11, 8'h3C},
    '{1'b1, 6'd11, 8'hEE, 8'h3C},
    '{1'b0, 6'd23, 8'h00, 8'hEE},
    '{1'b0, 6'd12, 8'h00, 8'h11},
    '{1'b1, 6'd63, 8'h77, 8'h11},
    '{1'b0, 6'd27, 8'h00, 8'h77},
    '{1'b0, 6'd11, 8'h00, 8'hEE}
  };

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 reqToggle = 1'b0;
  logic                 wrSel = 1'b0;
  logic [ADDR_IN_W-1:0] addr = '0;
  logic [DATA_W-1:0]    wrData = '0;
  logic                 ackToggle;
  logic [DATA_W-1:0]    rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DATA_W-1:0] refMem [DEPTH];
  logic [DATA_W-1:0] lastRd = '0;

  always #2.5 clk = ~clk;

  toggle_req_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_IN_W(ADDR_IN_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqToggle(reqToggle), .wrSel(wrSel),
    .addr(addr), .wrData(wrData), .ackToggle(ackToggle), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; issues one access and samples at the next falling edge.
  task automatic access(input logic w, input logic [ADDR_IN_W-1:0] a,
                        input logic [DATA_W-1:0] d, input string req);
    logic newTog;
    newTog    = ~reqToggle;
    wrSel     = w;
    addr      = a;
    wrData    = d;
    reqToggle = newTog;
    @(negedge clk);
    check({req, " R5 ack"}, 32'(ackToggle), 32'(newTog));
    if (w) begin
      refMem[int'(a) % DEPTH] = d;
      check({req, " R4 rd kept"}, 32'(rdData), 32'(lastRd));
    end else begin
      lastRd = refMem[int'(a) % DEPTH];
      check({req, " R2 read"}, 32'(rdData), 32'(lastRd));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    check("R7 reset ack", 32'(ackToggle), 32'd0);
    check("R7 reset rd", 32'(rdData), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Directed table (R3, R6 aliasing through wrapped addresses)
    for (int i = 0; i < 10; i++) begin
      access(VECS[i].wr, VECS[i].a, VECS[i].d, "R6 table");
      check("R3 R6 table expect", 32'(rdData), 32'(VECS[i].exp));
    end

    // Fill every word, then read each back through an alias (R3, R6)
    for (int i = 0; i < DEPTH; i++) access(1'b1, ADDR_IN_W'(i), DATA_W'(8'h40 + i), "R3 fill");
    for (int i = 0; i < DEPTH; i++) access(1'b0, ADDR_IN_W'(i + 2*DEPTH), 8'h00, "R6 alias read");

    // Idle: bits equal, inputs wiggle, nothing may change (R1)
    wrSel  = 1'b1;
    addr   = 6'd5;
    wrData = 8'h99;
    repeat (2) @(negedge clk);
    wrSel = 1'b0;
    addr  = 6'd7;
    repeat (2) @(negedge clk);
    check("R1 idle ack", 32'(ackToggle), 32'(reqToggle));
    check("R1 idle rd", 32'(rdData), 32'(lastRd));
    access(1'b0, 6'd5, 8'h00, "R1 word untouched");

    // Back-to-back random traffic, one access per cycle (R8)
    for (int i = 0; i < 400; i++) begin
      logic w;
      w = 1'($urandom);
      access(w, ADDR_IN_W'($urandom), DATA_W'($urandom), "R8 random");
    end

    // Reset mid-run: outputs clear, storage survives (R7)
    rstN = 1'b0;
    reqToggle = 1'b0;
    @(negedge clk);
    check("R7 mid reset ack", 32'(ackToggle), 32'd0);
    check("R7 mid reset rd", 32'(rdData), 32'd0);
    rstN = 1'b1;
    lastRd = '0;
    @(negedge clk);
    access(1'b0, 6'd2, 8'h00, "R7 storage kept");
    access(1'b0, 6'd9, 8'h00, "R7 storage kept");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule